// File: doc/BRIEF.md
# Multicycle Instruction Timing Sequencer

This block paces one instruction of a small, area-lean 16-bit processor through its execution phases. A one-cycle start pulse carries the instruction class, the source and destination addressing modes and the outcome of the branch condition. The sequencer then walks through a base phase, a source-operand phase and a destination-operand phase. It stays in each phase for the number of clock cycles that the class, the modes and the branch outcome call for. It does no datapath or memory work: it only produces the phase, busy and done timing that the rest of the core keys on.

The cycle total is the fixed base time plus the source cost plus the destination cost. Branch and subroutine-call classes have no source phase, and their destination cost depends on whether the branch is taken. A class or mode combination that has no defined operand cost raises an error flag, and the instruction then retires after the base phase alone. The computed total is reported for the most recently accepted instruction.

Top module: `op_timing_seq`

## Requirements
- R1: While reset is held and after it is released, phase is idle and busy, done, err and cycles are all 0.
- R2: Phase codes are idle 0, base 1, source 2, destination 3. A start seen while idle makes the next cycle a base cycle with busy high. The base phase lasts 2 cycles for every class.
- R3: Class codes are load 0, move 1, ALU 2, branch 3, call 4; 5 to 7 are undefined. Mode codes are register 0, indirect 1, pre-decrement 2, post-increment 3, displacement 4, quick immediate 5, port 6, full immediate 7, absolute 8, quick PC-relative 9, full PC-relative 10; 11 to 15 are undefined. For move and ALU the source phase lasts 1 cycle for register, quick immediate and port. It lasts 2 for indirect, post-increment and full immediate, 3 for pre-decrement, and 4 for displacement and absolute.
- R4: For move the destination phase lasts 3 cycles for displacement and absolute, and 2 for register, indirect, pre-decrement, post-increment and port.
- R5: For ALU the destination phase lasts 2 cycles for register and port, 3 for indirect and post-increment, 4 for pre-decrement, and 5 for displacement and absolute.
- R6: Branch and call have no source phase. When not taken, the destination phase lasts 3 cycles for displacement, full immediate and full PC-relative targets, and 2 for the other defined targets except absolute.
- R7: A taken branch's destination phase lasts 5 cycles for register, quick immediate, port and quick PC-relative targets. It lasts 6 for indirect, post-increment, full immediate and full PC-relative, 7 for pre-decrement and 8 for displacement.
- R8: A taken call's destination phase is one cycle longer than a taken branch with the same target. A call that is not taken is timed like a branch that is not taken.
- R9: Load ignores the source mode and always takes 1 source and 2 destination cycles (5 in total). It requires a register destination.
- R10: An undefined class or mode, absolute as a branch or call target, or quick immediate, full immediate or either PC-relative mode as a load, move or ALU destination is illegal. So is a PC-relative source for move or ALU, and any non-register load destination. Any of these holds err high for the whole run, and the run ends after the 2 base cycles with cycles reporting 2.
- R11: Done is high for exactly one cycle, the last busy cycle. The cycle after it is idle. The number of cycles from the start edge to done equals cycles, which is held until the next accepted start.
- R12: A start that arrives while busy is ignored: the running instruction's timing and its reported total do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| op_class_i | input | 3 | Instruction class code |
| src_mode_i | input | 4 | Source addressing mode code |
| dst_mode_i | input | 4 | Destination addressing mode code |
| taken_i | input | 1 | Branch condition outcome, sampled with start |
| busy_o | output | 1 | High while an instruction is running |
| done_o | output | 1 | One-cycle pulse in the final busy cycle |
| phase_o | output | 2 | Current phase code |
| err_o | output | 1 | Illegal combination flag, high during that run |
| cycles_o | output | CNT_W | Total cycle count of the last accepted instruction |

## Verification
The assertions watch on every cycle that done is a single pulse inside a run, that it is followed by idle, and that an accepted start opens a base phase lasting exactly two cycles. They also check that an erroring run never leaves the base phase, that a start arriving while busy leaves the reported total alone, and that the elapsed count from start to done equals the reported total. What those properties cannot see is whether each phase length matches the class, modes and branch outcome. Only the bench's sweep over every class, both modes and both branch outcomes can show that, by counting the cycles spent in each phase against tables held in the bench. The fixed reference totals and a start injected into a running instruction are shown by directed scenarios.

// File: rtl/op_timing_pkg.sv
// Shared codes for the instruction timing sequencer.
// Assumes class and mode inputs use these encodings; other values are undefined.
package op_timing_pkg;

    localparam int CLS_W  = 3;
    localparam int MODE_W = 4;

    typedef enum logic [CLS_W-1:0] {
        CL_LOAD   = 3'd0,
        CL_MOVE   = 3'd1,
        CL_ALU    = 3'd2,
        CL_BRANCH = 3'd3,
        CL_CALL   = 3'd4
    } op_class_e;

    typedef enum logic [MODE_W-1:0] {
        MD_REG     = 4'd0,
        MD_IND     = 4'd1,
        MD_PREDEC  = 4'd2,
        MD_POSTINC = 4'd3,
        MD_DISP    = 4'd4,
        MD_IMMQ    = 4'd5,
        MD_PORT    = 4'd6,
        MD_IMM     = 4'd7,
        MD_ABS     = 4'd8,
        MD_PCRELQ  = 4'd9,
        MD_PCREL   = 4'd10
    } op_mode_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_BASE = 2'd1,
        PH_SRC  = 2'd2,
        PH_DST  = 2'd3
    } phase_e;

endpackage

// File: rtl/op_cost_lut.sv
// Operand cost lookup.
// Purely combinational: turns class, modes and branch outcome into source and
// destination phase lengths, and flags combinations with no defined cost.
// Assumes lengths fit in CNT_W bits (largest is 9).
module op_cost_lut
    import op_timing_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic [CLS_W-1:0]  op_class_i,
    input  logic [MODE_W-1:0] src_mode_i,
    input  logic [MODE_W-1:0] dst_mode_i,
    input  logic              taken_i,
    output logic [CNT_W-1:0]  src_len_o,
    output logic [CNT_W-1:0]  dst_len_o,
    output logic              illegal_o
);

    logic [3:0] src_c,  mv_c,  alu_c,  nt_c,  tk_c;
    logic       src_ok, mv_ok, alu_ok, nt_ok, tk_ok;
    logic [3:0] src_sel, dst_sel;
    logic       ok_sel;

    // Source operand cost for move and ALU classes.
    always_comb begin
        src_ok = 1'b1;
        src_c  = 4'd0;
        case (src_mode_i)
            MD_REG, MD_IMMQ, MD_PORT:    src_c = 4'd1;
            MD_IND, MD_POSTINC, MD_IMM:  src_c = 4'd2;
            MD_PREDEC:                   src_c = 4'd3;
            MD_DISP, MD_ABS:             src_c = 4'd4;
            default:                     src_ok = 1'b0;
        endcase
    end

    // Destination cost for the move class.
    always_comb begin
        mv_ok = 1'b1;
        mv_c  = 4'd0;
        case (dst_mode_i)
            MD_REG, MD_IND, MD_PREDEC, MD_POSTINC, MD_PORT: mv_c = 4'd2;
            MD_DISP, MD_ABS:                                mv_c = 4'd3;
            default:                                        mv_ok = 1'b0;
        endcase
    end

    // Destination cost for the ALU class.
    always_comb begin
        alu_ok = 1'b1;
        alu_c  = 4'd0;
        case (dst_mode_i)
            MD_REG, MD_PORT:     alu_c = 4'd2;
            MD_IND, MD_POSTINC:  alu_c = 4'd3;
            MD_PREDEC:           alu_c = 4'd4;
            MD_DISP, MD_ABS:     alu_c = 4'd5;
            default:             alu_ok = 1'b0;
        endcase
    end

    // Target cost for a branch whose condition fails.
    always_comb begin
        nt_ok = 1'b1;
        nt_c  = 4'd0;
        case (dst_mode_i)
            MD_DISP, MD_IMM, MD_PCREL:                     nt_c = 4'd3;
            MD_REG, MD_IND, MD_PREDEC, MD_POSTINC,
            MD_IMMQ, MD_PORT, MD_PCRELQ:                   nt_c = 4'd2;
            default:                                       nt_ok = 1'b0;
        endcase
    end

    // Target cost for a taken branch.
    always_comb begin
        tk_ok = 1'b1;
        tk_c  = 4'd0;
        case (dst_mode_i)
            MD_REG, MD_IMMQ, MD_PORT, MD_PCRELQ:     tk_c = 4'd5;
            MD_IND, MD_POSTINC, MD_IMM, MD_PCREL:    tk_c = 4'd6;
            MD_PREDEC:                               tk_c = 4'd7;
            MD_DISP:                                 tk_c = 4'd8;
            default:                                 tk_ok = 1'b0;
        endcase
    end

    // Class selection of the two phase lengths and legality.
    always_comb begin
        src_sel = 4'd0;
        dst_sel = 4'd0;
        ok_sel  = 1'b0;
        case (op_class_i)
            CL_LOAD: begin
                src_sel = 4'd1;
                dst_sel = 4'd2;
                ok_sel  = (dst_mode_i == MD_REG);
            end
            CL_MOVE: begin
                src_sel = src_c;
                dst_sel = mv_c;
                ok_sel  = src_ok && mv_ok;
            end
            CL_ALU: begin
                src_sel = src_c;
                dst_sel = alu_c;
                ok_sel  = src_ok && alu_ok;
            end
            CL_BRANCH, CL_CALL: begin
                src_sel = 4'd0;
                if (taken_i) begin
                    dst_sel = (op_class_i == CL_CALL) ? tk_c + 4'd1 : tk_c;
                    ok_sel  = tk_ok;
                end else begin
                    dst_sel = nt_c;
                    ok_sel  = nt_ok;
                end
            end
            default: ok_sel = 1'b0;
        endcase
    end

    // Illegal combinations collapse to zero operand time.
    assign illegal_o = !ok_sel;
    assign src_len_o = ok_sel ? CNT_W'(src_sel) : '0;
    assign dst_len_o = ok_sel ? CNT_W'(dst_sel) : '0;

endmodule

// File: rtl/op_req_hold.sv
// Request capture.
// Latches phase lengths, error flag and total on an accepted start so that
// input changes during a run cannot alter it. Assumes accept_i is one cycle.
module op_req_hold #(
    parameter int CNT_W    = 4,
    parameter int BASE_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  logic [CNT_W-1:0] src_len_i,
    input  logic [CNT_W-1:0] dst_len_i,
    input  logic             illegal_i,
    output logic [CNT_W-1:0] src_len_o,
    output logic [CNT_W-1:0] dst_len_o,
    output logic             err_o,
    output logic [CNT_W-1:0] total_o
);

    localparam logic [CNT_W-1:0] BASE_LEN = CNT_W'(BASE_CYC);

    // Capture the instruction's timing when a new run is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_len_o <= '0;
            dst_len_o <= '0;
            err_o     <= 1'b0;
            total_o   <= '0;
        end else if (accept_i) begin
            src_len_o <= src_len_i;
            dst_len_o <= dst_len_i;
            err_o     <= illegal_i;
            total_o   <= BASE_LEN + src_len_i + dst_len_i;
        end
    end

endmodule

// File: rtl/op_phase_fsm.sv
// Phase sequencer.
// Walks base, source and destination phases with one down-counter, skipping
// empty phases, and flags the final cycle. Assumes BASE_CYC >= 1 so the
// latched lengths are valid before the base phase ends.
module op_phase_fsm
    import op_timing_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int BASE_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] src_len_i,
    input  logic [CNT_W-1:0] dst_len_i,
    output logic             accept_o,
    output phase_e           phase_o,
    output logic             done_o
);

    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);
    localparam logic [CNT_W-1:0] BASE_LAST = CNT_W'(BASE_CYC - 1);

    phase_e           phase_q, phase_n;
    logic [CNT_W-1:0] cnt_q,   cnt_n;

    assign accept_o = start_i && (phase_q == PH_IDLE);

    // Next phase and remaining-cycle count.
    always_comb begin
        phase_n = phase_q;
        cnt_n   = cnt_q;
        if (phase_q == PH_IDLE) begin
            if (start_i) begin
                phase_n = PH_BASE;
                cnt_n   = BASE_LAST;
            end
        end else if (cnt_q != '0) begin
            cnt_n = cnt_q - ONE;
        end else if (phase_q == PH_BASE && src_len_i != '0) begin
            phase_n = PH_SRC;
            cnt_n   = src_len_i - ONE;
        end else if (phase_q != PH_DST && dst_len_i != '0) begin
            phase_n = PH_DST;
            cnt_n   = dst_len_i - ONE;
        end else begin
            phase_n = PH_IDLE;
            cnt_n   = '0;
        end
    end

    // Phase and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_n;
            cnt_q   <= cnt_n;
        end
    end

    // Final cycle: a running phase that is about to return to idle.
    assign done_o  = (phase_q != PH_IDLE) && (phase_n == PH_IDLE);
    assign phase_o = phase_q;

endmodule

// File: rtl/op_timing_seq.sv
// Multicycle instruction timing sequencer, top level.
// Accepts a start while idle, computes operand costs, latches them and paces
// the phases. Assumes start is synchronous to clk; starts while busy are dropped.
module op_timing_seq
    import op_timing_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int BASE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CLS_W-1:0]  op_class_i,
    input  logic [MODE_W-1:0] src_mode_i,
    input  logic [MODE_W-1:0] dst_mode_i,
    input  logic              taken_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [1:0]        phase_o,
    output logic              err_o,
    output logic [CNT_W-1:0]  cycles_o
);

    logic [CNT_W-1:0] src_raw, dst_raw, src_q, dst_q;
    logic             illegal, err_q, accept;
    phase_e           phase;

    op_cost_lut #(.CNT_W(CNT_W)) u_cost (
        .op_class_i (op_class_i),
        .src_mode_i (src_mode_i),
        .dst_mode_i (dst_mode_i),
        .taken_i    (taken_i),
        .src_len_o  (src_raw),
        .dst_len_o  (dst_raw),
        .illegal_o  (illegal)
    );

    op_req_hold #(.CNT_W(CNT_W), .BASE_CYC(BASE_CYC)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (accept),
        .src_len_i (src_raw),
        .dst_len_i (dst_raw),
        .illegal_i (illegal),
        .src_len_o (src_q),
        .dst_len_o (dst_q),
        .err_o     (err_q),
        .total_o   (cycles_o)
    );

    op_phase_fsm #(.CNT_W(CNT_W), .BASE_CYC(BASE_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .src_len_i (src_q),
        .dst_len_i (dst_q),
        .accept_o  (accept),
        .phase_o   (phase),
        .done_o    (done_o)
    );

    // Status outputs derived from the phase.
    assign busy_o  = (phase != PH_IDLE);
    assign phase_o = phase;
    assign err_o   = err_q && busy_o;

endmodule

// File: rtl/op_timing_seq_chk.sv
// Property checker for the timing sequencer, bound to the top module.
// Keeps its own elapsed-cycle counter to compare against the reported total.
module op_timing_seq_chk #(
    parameter int CNT_W    = 4,
    parameter int BASE_CYC = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [1:0]       phase_o,
    input logic             err_o,
    input logic [CNT_W-1:0] cycles_o
);

    logic [CNT_W-1:0] elapsed;

    // Count cycles since the last accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)                  elapsed <= '0;
        else if (start_i && !busy_o) elapsed <= CNT_W'(1);
        else if (busy_o)             elapsed <= elapsed + CNT_W'(1);
    end

    // R11
    done_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11
    done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (phase_o == 2'd0));

    // R11
    latency_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (elapsed == cycles_o));

    // R2
    start_opens_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (phase_o == 2'd1 && busy_o));

    // R2
    base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd1 && elapsed < CNT_W'(BASE_CYC)) |=> (phase_o == 2'd1));

    // R12
    busy_start_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(cycles_o));

    // R10
    err_base_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (phase_o == 2'd1));

endmodule

bind op_timing_seq op_timing_seq_chk #(.CNT_W(CNT_W), .BASE_CYC(BASE_CYC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .phase_o  (phase_o),
    .err_o    (err_o),
    .cycles_o (cycles_o)
);

// File: tb/op_timing_seq_test.sv
`timescale 1ns/1ps
// Self-checking bench: full sweep of class, modes and branch outcome, plus
// reference totals and a start injected into a running instruction.
module op_timing_seq_test;

    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [2:0]       op_class_i = '0;
    logic [3:0]       src_mode_i = '0;
    logic [3:0]       dst_mode_i = '0;
    logic             taken_i = 1'b0;
    logic             busy_o, done_o, err_o;
    logic [1:0]       phase_o;
    logic [CNT_W-1:0] cycles_o;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    // Cost tables indexed by mode code; -1 marks an undefined cost.
    int src_tab [16] = '{1,2,3,2,4,1,1,2,4,-1,-1,-1,-1,-1,-1,-1};
    int mv_tab  [16] = '{2,2,2,2,3,-1,2,-1,3,-1,-1,-1,-1,-1,-1,-1};
    int alu_tab [16] = '{2,3,4,3,5,-1,2,-1,5,-1,-1,-1,-1,-1,-1,-1};
    int nt_tab  [16] = '{2,2,2,2,3,2,2,3,-1,2,3,-1,-1,-1,-1,-1};
    int tk_tab  [16] = '{5,6,7,6,8,5,5,6,-1,5,6,-1,-1,-1,-1,-1};

    op_timing_seq #(.CNT_W(CNT_W), .BASE_CYC(2)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .op_class_i (op_class_i),
        .src_mode_i (src_mode_i),
        .dst_mode_i (dst_mode_i),
        .taken_i    (taken_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .phase_o    (phase_o),
        .err_o      (err_o),
        .cycles_o   (cycles_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected source/destination lengths and error flag from the tables.
    task automatic expect_cost(input int c, input int s, input int d, input int t,
                               output int es, output int ed, output int ee);
        int a, b;
        a = -1; b = -1;
        case (c)
            0: begin a = 1; b = (d == 0) ? 2 : -1; end
            1: begin a = src_tab[s]; b = mv_tab[d]; end
            2: begin a = src_tab[s]; b = alu_tab[d]; end
            3: begin a = 0; b = t ? tk_tab[d] : nt_tab[d]; end
            4: begin a = 0; b = t ? tk_tab[d] : nt_tab[d];
                     if (t && b > 0) b = b + 1; end
            default: begin a = -1; b = -1; end
        endcase
        if (a < 0 || b < 0) begin es = 0; ed = 0; ee = 1; end
        else begin es = a; ed = b; ee = 0; end
    endtask

    // Issue one instruction and profile its phases; optionally inject a start mid-run.
    task automatic run_op(input int c, input int s, input int d, input int t, input int intrude,
                          output int lat, output int nb, output int ns, output int nd,
                          output int errv, output int cyc, output int idle_ok);
        @(negedge clk);
        op_class_i = 3'(c); src_mode_i = 4'(s); dst_mode_i = 4'(d); taken_i = 1'(t);
        start_i = 1'b1;
        lat = 0; nb = 0; ns = 0; nd = 0; errv = 0; cyc = -1; idle_ok = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            start_i = 1'b0;
            lat++;
            if (intrude > 0 && lat == intrude) begin
                start_i = 1'b1; op_class_i = 3'd0; dst_mode_i = 4'd0;
            end
            if (phase_o == 2'd1) nb++;
            if (phase_o == 2'd2) ns++;
            if (phase_o == 2'd3) nd++;
            if (err_o) errv = 1;
            if (done_o) begin
                cyc = int'(cycles_o);
                break;
            end
        end
        @(negedge clk);
        start_i = 1'b0;
        idle_ok = (!busy_o && phase_o == 2'd0 && !done_o) ? 1 : 0;
    endtask

    function automatic string tag_of(input int c, input int t, input int e);
        if (e) return "R10";
        case (c)
            0: return "R9";
            1: return "R4";
            2: return "R5";
            3: return t ? "R7" : "R6";
            default: return "R8";
        endcase
    endfunction

    initial begin
        int lat, nb, ns, nd, ev, cy, io, es, ed, ee;
        string tg;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs quiet while in reset
        chk("R1", "busy in reset", busy_o, 0);
        chk("R1", "phase in reset", phase_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy after reset", busy_o, 0);
        chk("R1", "done after reset", done_o, 0);
        chk("R1", "err after reset", err_o, 0);
        chk("R1", "cycles after reset", cycles_o, 0);

        // Full sweep over every class, source, destination and branch outcome.
        for (int c = 0; c < 8; c++)
            for (int s = 0; s < 16; s++)
                for (int d = 0; d < 16; d++)
                    for (int t = 0; t < 2; t++) begin
                        expect_cost(c, s, d, t, es, ed, ee);
                        tg = tag_of(c, t, ee);
                        run_op(c, s, d, t, 0, lat, nb, ns, nd, ev, cy, io);
                        chk(tg, "latency", lat, 2 + es + ed);
                        chk("R11", "reported total", cy, 2 + es + ed);
                        chk(tg, "err flag", ev, ee);
                        chk("R2", "base cycles", nb, 2);
                        chk((c == 1 || c == 2) ? "R3" : tg, "source cycles", ns, es);
                        chk(tg, "destination cycles", nd, ed);
                        chk("R11", "idle after done", io, 1);
                    end

        // Reference totals.
        run_op(1, 7, 4, 0, 0, lat, nb, ns, nd, ev, cy, io);
        chk("R4", "move imm to disp", lat, 7);
        run_op(2, 8, 8, 1, 0, lat, nb, ns, nd, ev, cy, io);
        chk("R5", "alu abs to abs", lat, 11);
        run_op(4, 0, 2, 1, 0, lat, nb, ns, nd, ev, cy, io);
        chk("R8", "call predec taken", lat, 10);
        run_op(4, 0, 2, 0, 0, lat, nb, ns, nd, ev, cy, io);
        chk("R8", "call predec not taken", lat, 4);
        run_op(0, 9, 0, 1, 0, lat, nb, ns, nd, ev, cy, io);
        chk("R9", "load total", lat, 5);

        // R12: start injected in cycles 3 and 9 of an 11-cycle run is dropped.
        run_op(2, 8, 8, 0, 3, lat, nb, ns, nd, ev, cy, io);
        chk("R12", "latency with mid-run start", lat, 11);
        chk("R12", "total with mid-run start", cy, 11);
        run_op(2, 8, 8, 0, 9, lat, nb, ns, nd, ev, cy, io);
        chk("R12", "latency with late start", lat, 11);
        chk("R12", "idle after late start", io, 1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL R11 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule